// File: doc/BRIEF.md
# Serial-Configured Clock Fan-Out Gate

This block sits beside an eighteen-way clock fan-out and decides, output by output, whether each copy of a reference clock is passed on or parked low. A host configures it over a two-wire serial bus, with the block acting as a write-only I2C slave receiver. The block watches SCL and SDA with a local sampling clock and pulls SDA low through an open-drain enable output to acknowledge. It has no read path, no sub-addressing, no clock stretching and no master capability.

A configuration transfer is a start condition, then the write address byte 0xD2, a command byte and a byte-count byte (both acknowledged, both ignored), then up to three enable bytes in fixed order. Further bytes are acknowledged and dropped. A separate drive-enable pin switches all eighteen tri-state controls off together. This is intended for board test. Enable changes are carried into the reference-clock domain and applied only while the reference is low, so no gated output ever emits a shortened high pulse.

Top module: `clkfan_i2c_gate`

## Requirements
- R1: After reset all 18 enables are 1, so every output follows the reference clock.
- R2: The block acknowledges the address byte 0xD2 (7-bit address 1101001 followed by write bit 0). Any other address byte, including the read form 0xD3, is not acknowledged, and the block then acknowledges nothing and changes nothing until the next start condition.
- R3: Bytes are shifted in MSB first on SCL rising edges. To acknowledge, the block drives SDA low from the falling SCL edge after the eighth bit until the falling edge after the ninth pulse. It asserts and releases sda_oe only while SCL is low.
- R4: The two bytes that follow an accepted address (command and count) are acknowledged and have no effect on any enable.
- R5: Data bytes load, in order, control byte A (bit n enables output n, n = 0..7), then control byte B (bit n enables output n+8), then control byte C (bit 7 enables output 17, bit 6 enables output 16, bits 5..0 ignored). A bit value of 1 enables the output.
- R6: Data bytes after the third are acknowledged and discarded.
- R7: A stop condition ends the transfer, leaving any control bytes not yet sent unchanged. A start condition, repeated or not, restarts the sequence at the address byte, so the next data byte again goes to control byte A.
- R8: An enabled output is a non-inverted copy of ref_clk, and a disabled output is held at 0.
- R9: With drv_en at 0, every bit of clk_oe is 0; with drv_en at 1, every bit is 1.
- R10: The enable seen by the outputs changes only while ref_clk is low, so every high pulse on an output lasts a full reference high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local sampling clock for the serial bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | 1 pulls the data line low (acknowledge) |
| ref_clk | input | 1 | Reference clock to fan out |
| drv_en | input | 1 | 0 places all outputs in high impedance |
| clk_out | output | 18 | Gated copies of ref_clk |
| clk_oe | output | 18 | Tri-state drive control per output, 1 = drive |

## Verification
SCL and SDA pass through a two-stage synchronizer and an edge register, so an acknowledge rises about three sampling-clock cycles after the falling SCL edge. The bench therefore reads the acknowledge in the middle of the following high phase, 200 ns later, and checks the release 100 ns into the low phase after it. A committed control byte reaches the outputs after two falling reference edges. The scoreboard monitor waits four falling edges after each pushed expectation and then samples mid-high and mid-low of the reference. Pulse integrity is checked continuously by measuring every high pulse on output 0 against the reference half-period.

// File: rtl/clkfan_i2c_gate.sv
module clkfan_i2c_gate #(
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int         SYNC     = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_oe,
  input  logic        ref_clk,
  input  logic        drv_en,
  output logic [17:0] clk_out,
  output logic [17:0] clk_oe
);

  localparam logic [7:0] WR_ADDR = {DEV_ADDR, 1'b0};
  localparam logic [2:0] PH_ADDR = 3'd0;
  localparam logic [2:0] PH_B0   = 3'd3;
  localparam logic [2:0] PH_B1   = 3'd4;
  localparam logic [2:0] PH_B2   = 3'd5;
  localparam logic [2:0] PH_DROP = 3'd6;

  logic [SYNC-1:0] scl_sh, sda_sh;
  logic            scl_d, sda_d;
  logic            scl_s, sda_s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[SYNC-2:0], scl_i};
      sda_sh <= {sda_sh[SYNC-2:0], sda_i};
      scl_d  <= scl_s;
      sda_d  <= sda_s;
    end

  assign scl_s = scl_sh[SYNC-1];
  assign sda_s = sda_sh[SYNC-1];

  logic start_det, stop_det, scl_rise, scl_fall;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;

  logic       active;
  logic [3:0] bitcnt;
  logic [2:0] phase;
  logic [7:0] shreg;
  logic [7:0] ctl_a, ctl_b;
  logic [1:0] ctl_c;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      active <= 1'b0;
      bitcnt <= '0;
      phase  <= PH_ADDR;
      shreg  <= '0;
      sda_oe <= 1'b0;
      ctl_a  <= '1;
      ctl_b  <= '1;
      ctl_c  <= '1;
    end else if (start_det) begin
      active <= 1'b1;
      bitcnt <= '0;
      phase  <= PH_ADDR;
      sda_oe <= 1'b0;
    end else if (stop_det) begin
      active <= 1'b0;
      sda_oe <= 1'b0;
    end else if (active) begin
      if (scl_rise && bitcnt < 4'd8) begin
        shreg  <= {shreg[6:0], sda_s};
        bitcnt <= bitcnt + 4'd1;
      end else if (scl_fall && bitcnt == 4'd8) begin
        if (sda_oe) begin
          sda_oe <= 1'b0;
          bitcnt <= '0;
        end else if (phase == PH_ADDR && shreg != WR_ADDR) begin
          active <= 1'b0;
        end else begin
          sda_oe <= 1'b1;
          if (phase != PH_DROP) phase <= phase + 3'd1;
          case (phase)
            PH_B0:   ctl_a <= shreg;
            PH_B1:   ctl_b <= shreg;
            PH_B2:   ctl_c <= shreg[7:6];
            default: ;
          endcase
        end
      end
    end

  logic [17:0] en_cfg, en_mid, en_ref;
  assign en_cfg = {ctl_c, ctl_b, ctl_a};

  always_ff @(negedge ref_clk or negedge rst_n)
    if (!rst_n) begin
      en_mid <= '1;
      en_ref <= '1;
    end else begin
      en_mid <= en_cfg;
      en_ref <= en_mid;
    end

  assign clk_out = {18{ref_clk}} & en_ref;
  assign clk_oe  = {18{drv_en}};

endmodule

module clkfan_i2c_gate_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        scl_i,
  input logic        ref_clk,
  input logic        sda_oe,
  input logic        start_det,
  input logic        active,
  input logic [2:0]  phase,
  input logic [17:0] en_cfg,
  input logic [17:0] en_ref
);

  // R3
  ack_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_i);

  // R3
  ack_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe) |-> !scl_i);

  // R7
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (active && phase == 3'd0 && !sda_oe));

  // R5
  cfg_in_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(en_cfg) |-> $past(active));

  // R10
  ref_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(en_ref) |-> !ref_clk);

endmodule

bind clkfan_i2c_gate clkfan_i2c_gate_chk u_chk (.*);

// File: tb/sim_clkfan_i2c_gate.sv
module sim_clkfan_i2c_gate;

  logic        clk = 0, rst_n = 0, ref_clk = 0, drv_en = 1;
  logic        scl = 1, sda_m = 1;
  logic        sda_oe;
  logic        sda_bus;
  logic [17:0] clk_out, clk_oe;

  assign sda_bus = sda_m & ~sda_oe;

  clkfan_i2c_gate u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .ref_clk(ref_clk), .drv_en(drv_en), .clk_out(clk_out), .clk_oe(clk_oe)
  );

  always #5 clk = ~clk;
  initial begin #3; forever #20 ref_clk = ~ref_clk; end

  int total = 0, bad = 0;
  int npush = 0, npop = 0;
  bit busy = 0;
  logic [18:0] exp_q[$];
  string       tag_q[$];
  logic [7:0]  e0 = 8'hFF, e1 = 8'hFF, e2 = 8'hFF;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [17:0] cur_en();
    return {e2[7], e2[6], e1, e0};
  endfunction

  task automatic expect_state(input bit oe, input string req);
    exp_q.push_back({oe, cur_en()});
    tag_q.push_back(req);
    npush++;
    wait (npop == npush && !busy);
  endtask

  initial begin
    forever begin
      logic [18:0] it;
      string       tg;
      wait (npush != npop);
      busy = 1;
      it = exp_q.pop_front();
      tg = tag_q.pop_front();
      npop++;
      repeat (4) @(negedge ref_clk);
      @(posedge ref_clk); #5;
      check({tg, " R9 clk_oe"}, 32'(clk_oe), 32'({18{it[18]}}));
      if (it[18]) check({tg, " R8 high phase"}, 32'(clk_out), 32'(it[17:0]));
      @(negedge ref_clk); #5;
      check({tg, " R8 low phase"}, 32'(clk_out), 32'd0);
      busy = 0;
    end
  end

  int  pulses = 0, short_pulses = 0;
  initial begin
    forever begin
      time t0;
      @(posedge clk_out[0]);
      t0 = $time;
      @(negedge clk_out[0]);
      pulses++;
      if ($time - t0 != 20) short_pulses++;
    end
  end

  task automatic i2c_start();
    sda_m = 1; #100; scl = 1; #200; sda_m = 0; #200; scl = 0; #100;
  endtask

  task automatic i2c_stop();
    sda_m = 0; #100; scl = 1; #200; sda_m = 1; #200;
  endtask

  task automatic send(input logic [7:0] b, input bit exp_ack, input string req);
    bit ack;
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; #100; scl = 1; #200; scl = 0; #100;
    end
    sda_m = 1; #100; scl = 1; #100;
    ack = !sda_bus;
    #100; scl = 0; #100;
    check({req, " ack"}, 32'(ack), 32'(exp_ack));
    if (exp_ack) check("R3 ack released after ninth pulse", 32'(sda_oe), 32'd0);
  endtask

  task automatic preamble();
    i2c_start();
    send(8'hD2, 1, "R2 address");
    send(8'h5A, 1, "R4 command");
    send(8'hC3, 1, "R4 count");
  endtask

  initial begin
    #1;
    #50 rst_n = 1;
    #400;
    check("R1 reset no ack", 32'(sda_oe), 32'd0);
    expect_state(1, "R1 reset all enabled");

    preamble();
    send(8'hA5, 1, "R5 byte A");
    i2c_stop();
    e0 = 8'hA5;
    expect_state(1, "R5 byte A only");

    preamble();
    send(8'h00, 1, "R5 byte A");
    send(8'h3C, 1, "R5 byte B");
    i2c_stop();
    e0 = 8'h00; e1 = 8'h3C;
    expect_state(1, "R5 bytes A,B");

    preamble();
    send(8'h0F, 1, "R5 byte A");
    send(8'hF0, 1, "R5 byte B");
    send(8'hBF, 1, "R5 byte C");
    i2c_stop();
    e0 = 8'h0F; e1 = 8'hF0; e2 = 8'hBF;
    expect_state(1, "R5 byte C maps 17,16");

    preamble();
    send(8'h81, 1, "R5 byte A");
    send(8'h42, 1, "R5 byte B");
    send(8'h40, 1, "R5 byte C");
    send(8'hFF, 1, "R6 extra byte");
    send(8'h00, 1, "R6 extra byte");
    i2c_stop();
    e0 = 8'h81; e1 = 8'h42; e2 = 8'h40;
    expect_state(1, "R6 extra bytes dropped");

    i2c_start();
    send(8'hA4, 0, "R2 wrong address");
    send(8'h00, 0, "R2 ignored");
    send(8'h00, 0, "R2 ignored");
    send(8'h00, 0, "R2 ignored");
    i2c_stop();
    expect_state(1, "R2 wrong address no change");

    i2c_start();
    send(8'hD3, 0, "R2 read address");
    send(8'h00, 0, "R2 ignored");
    i2c_stop();
    expect_state(1, "R2 read address no change");

    i2c_start();
    send(8'hD2, 1, "R7 address");
    send(8'h00, 1, "R4 command");
    i2c_stop();
    expect_state(1, "R7 stop before data no change");

    preamble();
    send(8'h7E, 1, "R7 byte A after stop");
    i2c_stop();
    e0 = 8'h7E;
    expect_state(1, "R7 new transfer from address");

    preamble();
    send(8'h55, 1, "R7 byte A");
    preamble();
    send(8'h11, 1, "R7 byte A after restart");
    i2c_stop();
    e0 = 8'h11;
    expect_state(1, "R7 repeated start to byte A");

    drv_en = 0;
    expect_state(0, "R9 drive disabled");
    drv_en = 1;
    expect_state(1, "R9 drive restored");

    rst_n = 0; #30; rst_n = 1;
    e0 = 8'hFF; e1 = 8'hFF; e2 = 8'hFF;
    expect_state(1, "R1 reset restores all enabled");

    check("R10 pulses seen", 32'(pulses > 10), 32'd1);
    check("R10 short pulses", 32'(short_pulses), 32'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    check("watchdog expired", 32'd1, 32'd0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule